// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the instruction address for a small microcontroller core. The count is 13 bits wide. Software can see and write only its low byte. The upper five bits are never computed by the core. They are copied from a separately written high-address latch whenever the low byte is written or a branch is taken.

A branch (jump or call) supplies an 11-bit target from the opcode. The two top address bits then come from the upper two latch bits. A write of an ALU result to the low byte takes all five latch bits as the upper address. For this reason, a computed jump whose addition overflows the low byte stays in the page the latch names, and no carry reaches the upper bits.

A return loads the full 13-bit value popped from the return stack. Without any load, the count steps by one per instruction cycle. The decoder, the ALU, the stack and program memory sit outside this block.

Top module: `paged_pc_unit`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `pc_o` and `hi_latch_o` both become 0 after that edge, whatever the other inputs are.
- R2: With no load strobe and `step_en` high, `pc_o` grows by one per clock and wraps from 0x1FFF to 0x0000.
- R3: A low-byte write (`lo_wr_en`) loads `pc_o[7:0]` with `lo_wr_data` and `pc_o[12:8]` with latch bits [4:0].
- R4: A jump or call (`jmp_en`) loads `pc_o[10:0]` with `jmp_target` and `pc_o[12:11]` with latch bits [4:3].
- R5: A return (`ret_en`) loads all 13 bits of `pc_o` from `ret_addr`, and the latch has no effect on the result.
- R6: Priority, from highest to lowest: reset, return, jump/call, low-byte write, step. Any load overrides the step.
- R7: With no strobe asserted, `pc_o` keeps its value.
- R8: `hi_latch_o` changes only through `hi_wr_en`, and takes `hi_wr_data` on the next edge. Returns and jumps/calls leave it unchanged.
- R9: A latch write in the same cycle as a low-byte write or a jump/call has no effect on that load. The load uses the latch value held before the write.
- R10: `pc_lo_o` always equals `pc_o[7:0]`.
- R11: A low-byte write never carries into the upper bits. With the count at 0x0AFF, the latch at 0x0A and data 0x05, the result is 0x0A05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance by one this cycle |
| lo_wr_en | input | 1 | Write ALU result into the low byte |
| lo_wr_data | input | 8 | ALU result for the low byte |
| jmp_en | input | 1 | Jump or call taken |
| jmp_target | input | 11 | Target field of the opcode |
| ret_en | input | 1 | Return: load popped address |
| ret_addr | input | 13 | Address popped from the stack |
| hi_wr_en | input | 1 | Write the high-address latch |
| hi_wr_data | input | 5 | New latch value |
| pc_o | output | 13 | Current program counter |
| pc_lo_o | output | 8 | Readable low byte |
| hi_latch_o | output | 5 | Current latch value |

## Verification
The collision that matters is a latch write in the same cycle as a load that reads the latch. A low-byte write or a jump/call must use the old latch value, while the latch itself takes the new value. The bench forces this case with directed cycles that change the latch to a distinctly different page. It also occurs often in the random phase, where each strobe is drawn on its own. The outcome is judged from the page bits of `pc_o` and from `hi_latch_o` on the following cycle.

// File: rtl/pcu_pkg.sv
// Shared types for the paged program counter unit.
// Assumes nothing beyond SystemVerilog 2017 enums.
package pcu_pkg;

    // Which source feeds the counter on the next edge.
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_STEP = 3'd1,
        SRC_LOWR = 3'd2,
        SRC_JUMP = 3'd3,
        SRC_RET  = 3'd4,
        SRC_RST  = 3'd5
    } pc_src_e;

endpackage

// File: rtl/pcu_src_arbiter.sv
// Picks the single source that updates the counter in this cycle.
// Fixed priority: reset, return, jump/call, low-byte write, step.
// Assumes strobes are synchronous to clk.
module pcu_src_arbiter
    import pcu_pkg::*;
(
    input  logic    rst_n,
    input  logic    ret_en,
    input  logic    jmp_en,
    input  logic    lo_wr_en,
    input  logic    step_en,
    output pc_src_e src
);

    // Priority encode the load requests.
    always_comb begin
        if (!rst_n)        src = SRC_RST;
        else if (ret_en)   src = SRC_RET;
        else if (jmp_en)   src = SRC_JUMP;
        else if (lo_wr_en) src = SRC_LOWR;
        else if (step_en)  src = SRC_STEP;
        else               src = SRC_HOLD;
    end

endmodule

// File: rtl/pcu_next_addr.sv
// Forms the next counter value for the selected source.
// Page bits on loads come from the latch; steps wrap at the top.
// Assumes TGT_W and LO_W are both below PC_W.
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int TGT_W = 11,
    localparam int HI_W  = PC_W - LO_W,
    localparam int JHI_W = PC_W - TGT_W
) (
    input  pc_src_e          src,
    input  logic [PC_W-1:0]  pc_q,
    input  logic [HI_W-1:0]  hi_latch,
    input  logic [LO_W-1:0]  lo_wr_data,
    input  logic [TGT_W-1:0] jmp_target,
    input  logic [PC_W-1:0]  ret_addr,
    output logic [PC_W-1:0]  pc_d
);

    logic [JHI_W-1:0] jump_page;

    // Jumps take only the topmost latch bits as page.
    assign jump_page = hi_latch[HI_W-1 -: JHI_W];

    // Select the next address.
    always_comb begin
        unique case (src)
            SRC_RST:  pc_d = '0;
            SRC_RET:  pc_d = ret_addr;
            SRC_JUMP: pc_d = {jump_page, jmp_target};
            SRC_LOWR: pc_d = {hi_latch, lo_wr_data};
            SRC_STEP: pc_d = PC_W'(pc_q + 1'b1);
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pcu_hi_latch.sv
// High-address latch written only through its own write port.
// Stack and branch traffic never touch it.
module pcu_hi_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);

    // Clear on reset, else capture written value.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end

endmodule

// File: rtl/paged_pc_unit.sv
// Paged program counter: low byte from ALU or steps, page from a latch.
// Loads read the latch value held before any same-cycle latch write.
// Assumes one instruction cycle per clock.
module paged_pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int TGT_W = 11,
    localparam int HI_W = PC_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             lo_wr_en,
    input  logic [LO_W-1:0]  lo_wr_data,
    input  logic             jmp_en,
    input  logic [TGT_W-1:0] jmp_target,
    input  logic             ret_en,
    input  logic [PC_W-1:0]  ret_addr,
    input  logic             hi_wr_en,
    input  logic [HI_W-1:0]  hi_wr_data,
    output logic [PC_W-1:0]  pc_o,
    output logic [LO_W-1:0]  pc_lo_o,
    output logic [HI_W-1:0]  hi_latch_o
);

    pc_src_e         src;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;

    pcu_src_arbiter u_arb (
        .rst_n    (rst_n),
        .ret_en   (ret_en),
        .jmp_en   (jmp_en),
        .lo_wr_en (lo_wr_en),
        .step_en  (step_en),
        .src      (src)
    );

    pcu_hi_latch #(.W(HI_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hi_wr_en),
        .wr_data (hi_wr_data),
        .q       (hi_latch_o)
    );

    pcu_next_addr #(.PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W)) u_next (
        .src        (src),
        .pc_q       (pc_q),
        .hi_latch   (hi_latch_o),
        .lo_wr_data (lo_wr_data),
        .jmp_target (jmp_target),
        .ret_addr   (ret_addr),
        .pc_d       (pc_d)
    );

    // Counter register; reset is folded into the source select.
    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    assign pc_o    = pc_q;
    assign pc_lo_o = pc_q[LO_W-1:0];

endmodule

// File: rtl/pcu_checker.sv
// Temporal checks on the paged program counter, bound to the top.
module pcu_checker #(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int TGT_W = 11,
    localparam int HI_W  = PC_W - LO_W,
    localparam int JHI_W = PC_W - TGT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             lo_wr_en,
    input logic [LO_W-1:0]  lo_wr_data,
    input logic             jmp_en,
    input logic [TGT_W-1:0] jmp_target,
    input logic             ret_en,
    input logic [PC_W-1:0]  ret_addr,
    input logic             hi_wr_en,
    input logic [PC_W-1:0]  pc_o,
    input logic [HI_W-1:0]  hi_latch_o
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && hi_latch_o == '0));

    // R2
    step_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !lo_wr_en && !jmp_en && !ret_en)
        |=> pc_o == PC_W'($past(pc_o) + 1'b1));

    // R3
    lowr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_en && !jmp_en && !ret_en)
        |=> pc_o == {$past(hi_latch_o), $past(lo_wr_data)});

    // R4
    jump_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_en && !ret_en)
        |=> pc_o == {$past(hi_latch_o[HI_W-1 -: JHI_W]), $past(jmp_target)});

    // R5
    ret_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> pc_o == $past(ret_addr));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !lo_wr_en && !jmp_en && !ret_en) |=> $stable(pc_o));

    // R8
    latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr_en |=> $stable(hi_latch_o));

endmodule

bind paged_pc_unit pcu_checker #(.PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W)) u_pcu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .lo_wr_en   (lo_wr_en),
    .lo_wr_data (lo_wr_data),
    .jmp_en     (jmp_en),
    .jmp_target (jmp_target),
    .ret_en     (ret_en),
    .ret_addr   (ret_addr),
    .hi_wr_en   (hi_wr_en),
    .pc_o       (pc_o),
    .hi_latch_o (hi_latch_o)
);

// File: tb/paged_pc_unit_bench.sv
// Self-checking bench: directed corners then seeded random cycles.
module paged_pc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_en, lo_wr_en, jmp_en, ret_en, hi_wr_en;
    logic [7:0]  lo_wr_data;
    logic [10:0] jmp_target;
    logic [12:0] ret_addr;
    logic [4:0]  hi_wr_data;
    logic [12:0] pc_o;
    logic [7:0]  pc_lo_o;
    logic [4:0]  hi_latch_o;

    int total = 0;
    int bad   = 0;
    logic [12:0] exp_pc  = '0;
    logic [4:0]  exp_lat = '0;

    always #2 clk = ~clk;

    paged_pc_unit u_paged_pc_unit (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
        .jmp_en(jmp_en), .jmp_target(jmp_target),
        .ret_en(ret_en), .ret_addr(ret_addr),
        .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
        .pc_o(pc_o), .pc_lo_o(pc_lo_o), .hi_latch_o(hi_latch_o)
    );

    // Expected counter from the requirement rules.
    function automatic logic [12:0] model_pc(
        input logic r, input logic rt, input logic [12:0] ra,
        input logic j, input logic [10:0] jt,
        input logic lw, input logic [7:0] ld,
        input logic s, input logic [12:0] pc, input logic [4:0] lat);
        if (!r)      return 13'h0000;
        else if (rt) return ra;
        else if (j)  return {lat[4:3], jt};
        else if (lw) return {lat, ld};
        else if (s)  return pc + 13'd1;
        else         return pc;
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One instruction cycle: drive at negedge, check at the next negedge.
    task automatic cyc(input logic r, input logic s, input logic lw, input logic [7:0] ld,
                       input logic j, input logic [10:0] jt, input logic rt,
                       input logic [12:0] ra, input logic hw, input logic [4:0] hd,
                       input string tag);
        rst_n = r; step_en = s; lo_wr_en = lw; lo_wr_data = ld;
        jmp_en = j; jmp_target = jt; ret_en = rt; ret_addr = ra;
        hi_wr_en = hw; hi_wr_data = hd;
        exp_pc  = model_pc(r, rt, ra, j, jt, lw, ld, s, exp_pc, exp_lat);
        exp_lat = !r ? 5'd0 : (hw ? hd : exp_lat);
        @(posedge clk);
        @(negedge clk);
        check({tag, " pc"}, pc_o, exp_pc);
        check("R8 latch", {8'd0, hi_latch_o}, {8'd0, exp_lat});
        check("R10 low byte", {5'd0, pc_lo_o}, {5'd0, pc_o[7:0]});
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1 reset with noisy inputs
        cyc(0, 1, 1, 8'hAA, 1, 11'h7FF, 1, 13'h1234, 1, 5'h1F, "R1 reset");
        // R7 idle hold
        cyc(1, 0, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 0, 5'h00, "R7 hold");
        // R2 wrap: return to top then step
        cyc(1, 0, 0, 8'h00, 0, 11'h000, 1, 13'h1FFF, 0, 5'h00, "R5 return");
        cyc(1, 1, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 0, 5'h00, "R2 wrap");
        cyc(1, 1, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 0, 5'h00, "R2 step");
        // R4 jump with latch 10110: page bits 10
        cyc(1, 0, 0, 8'h00, 0, 11'h000, 0, 13'h0000, 1, 5'b10110, "R8 write");
        cyc(1, 1, 0, 8'h00, 1, 11'h155, 0, 13'h0000, 0, 5'h00, "R4 jump");
        // R3 low write uses full latch
        cyc(1, 1, 1, 8'h3C, 0, 11'h000, 0, 13'h0000, 0, 5'h00, "R3 lowr");
        // R5 return ignores latch, R8 latch unchanged
        cyc(1, 0, 0, 8'h00, 0, 11'h000, 1, 13'h0ABC, 0, 5'h00, "R5 ret latch-free");
        // R11 no carry: pc 0x0AFF, latch 0x0A, data 0x05
        cyc(1, 0, 0, 8'h00, 0, 11'h000, 1, 13'h0AFF, 1, 5'h0A, "R5 setup");
        cyc(1, 0, 1, 8'h05, 0, 11'h000, 0, 13'h0000, 0, 5'h00, "R11 no carry");
        check("R11 value", pc_o, 13'h0A05);
        // R9 latch write alongside low write and jump
        cyc(1, 0, 1, 8'h77, 0, 11'h000, 0, 13'h0000, 1, 5'h13, "R9 lowr+latch");
        check("R9 old page", {8'd0, pc_o[12:8]}, 13'h000A);
        cyc(1, 0, 0, 8'h00, 1, 11'h0F0, 0, 13'h0000, 1, 5'h04, "R9 jump+latch");
        check("R9 jump page", {11'd0, pc_o[12:11]}, 13'd2);
        // R6 priority ladders
        cyc(1, 1, 1, 8'h11, 1, 11'h222, 1, 13'h1333, 0, 5'h00, "R6 ret wins");
        cyc(1, 1, 1, 8'h11, 1, 11'h222, 0, 13'h0000, 0, 5'h00, "R6 jump wins");
        cyc(1, 1, 1, 8'h11, 0, 11'h000, 0, 13'h0000, 0, 5'h00, "R6 lowr wins");
        cyc(0, 1, 1, 8'h11, 1, 11'h222, 1, 13'h1333, 0, 5'h00, "R6 reset wins");
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            automatic logic r  = ($urandom % 64) != 0;
            automatic logic rt = ($urandom % 6) == 0;
            automatic logic j  = ($urandom % 5) == 0;
            automatic logic lw = ($urandom % 4) == 0;
            automatic logic s  = ($urandom % 4) != 0;
            automatic logic hw = ($urandom % 3) == 0;
            automatic string tg;
            if (!r) tg = "R1 rand";
            else if (rt) tg = "R5 rand";
            else if (j) tg = "R4 rand";
            else if (lw) tg = (hw ? "R9 rand" : "R3 rand");
            else if (s) tg = "R2 rand";
            else tg = "R7 rand";
            cyc(r, s, lw, 8'($urandom), j, 11'($urandom), rt, 13'($urandom),
                hw, 5'($urandom), tg);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule